// File: doc/BRIEF.md
# Debug-Masked Instruction Fetch Counter

This block keeps a running total of a processor core's instruction fetches. The total does not depend on whether the program was stopped by a debugger. The block watches the core's active-low instruction request and its raw debug acknowledge. From these it derives a corrected acknowledge that hides fetches tied to debug activity. A fetch adds to the total only while that corrected acknowledge is low.

The raw acknowledge cannot be trusted on its own. It can stay high well past the point where the core has re-fetched the halted instruction and its two prefetched successors. A restart pulse marks a real exit from debug. After a restart the block opens a window of exactly three fetches, all masked, and then drops the corrected acknowledge, whatever the raw level is doing. With no restart, the raw acknowledge going high (for example during system-speed memory accesses made from debug) raises the mask. The mask falls again only when the raw acknowledge falls.

A small state machine handles the masking. It has three states: `ST_RUN` (counting), `ST_HALT` (masked and following the raw acknowledge) and `ST_EXIT` (the three-fetch exit window). It has these transitions:
- RUN to HALT on a raw acknowledge rising edge.
- HALT to EXIT on a restart pulse.
- HALT to RUN when the raw acknowledge is low and there is no restart.
- EXIT to RUN on the third fetch in the window.
- EXIT to HALT on a raw acknowledge rising edge, which also resets the window.

A separate tally register counts the qualified fetches.

Top module: `ifetch_census`

## Requirements
- R1: A synchronous active-low reset drives the corrected acknowledge low, the window to zero, the tally to zero and the pulse low.
- R2: A fetch is a rising clock edge with the request input low. If the corrected acknowledge is low at that edge, the tally is one higher and the pulse is high in the following cycle. Otherwise the pulse is low.
- R3: In `ST_RUN`, a rising edge of the raw acknowledge raises the corrected acknowledge in the next cycle. While the corrected acknowledge is high, fetches leave the tally unchanged.
- R4: In `ST_HALT` with the raw acknowledge low and no restart, the corrected acknowledge falls in the next cycle.
- R5: A restart pulse in `ST_HALT` starts the exit window. The corrected acknowledge stays high through exactly three fetches. It is low in the cycle after the edge of the third fetch, and none of the three is counted.
- R6: The level of the raw acknowledge does not affect the exit window. A raw acknowledge that stays high after the third fetch keeps the acknowledge low, and later fetches are counted.
- R7: A raw acknowledge rising edge during the exit window returns the block to `ST_HALT` with the window cleared. A later restart then needs three full fetches again.
- R8: The clear input empties the tally in the next cycle and wins over a same-cycle increment.
- R9: The tally wraps from its all-ones value to zero.
- R10: A counted fetch in the same cycle as a clear still produces the pulse.
- R11: A restart pulse outside `ST_HALT` has no effect on the corrected acknowledge or the tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ifetch_req_n | input | 1 | Instruction request from the core, active low |
| dbg_ack_raw | input | 1 | Raw debug acknowledge from the core |
| dbg_restart | input | 1 | One-cycle pulse marking a real exit from debug |
| tally_clr | input | 1 | Synchronous clear of the tally |
| dbg_ack_mod | output | 1 | Corrected debug acknowledge (fetch mask) |
| fetch_tally | output | CNT_W | Number of counted fetches |
| tally_pulse | output | 1 | High for one cycle after each counted fetch |

## Verification
The stimulus covers several fetch patterns:
- Plain fetches with the acknowledge low.
- System-speed bursts, where the acknowledge is high and there is no restart. These tell real exits apart from memory accesses.
- An exit where the raw acknowledge stays high past the third fetch. This separates the three-fetch rule from simply following the raw signal.
- An exit where the raw acknowledge falls and then rises again mid-window. This checks that the window is discarded.

Clears that coincide with a fetch show the clear priority and the surviving pulse. A narrow-tally instance shows the wrap.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_EXIT = 2'd2
    } mask_state_t;

endpackage

// File: rtl/ifc_fetch_qual.sv
module ifc_fetch_qual (
    input  logic ifetch_req_n,
    input  logic mask,
    output logic fetch_hit,
    output logic count_en
);

    always_comb begin
        fetch_hit = ~ifetch_req_n;
        count_en  = fetch_hit & ~mask;
    end

endmodule

// File: rtl/ifc_mask_fsm.sv
module ifc_mask_fsm #(
    parameter int WIN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_hit,
    input  logic dbg_ack_raw,
    input  logic dbg_restart,
    output logic mask_o
);
    import ifc_pkg::*;

    localparam int WIN_W = (WIN_LEN < 2) ? 1 : $clog2(WIN_LEN);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

    mask_state_t      state_q, state_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic             raw_q;
    logic             ack_rose;

    assign ack_rose = dbg_ack_raw & ~raw_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            win_q   <= '0;
            raw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            win_q   <= win_d;
            raw_q   <= dbg_ack_raw;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        unique case (state_q)
            ST_RUN: begin
                win_d = '0;
                if (ack_rose) state_d = ST_HALT;
            end
            ST_HALT: begin
                win_d = '0;
                if (dbg_restart)       state_d = ST_EXIT;
                else if (!dbg_ack_raw) state_d = ST_RUN;
            end
            ST_EXIT: begin
                if (ack_rose) begin
                    state_d = ST_HALT;
                    win_d   = '0;
                end else if (fetch_hit) begin
                    if (win_q == WIN_LAST) begin
                        state_d = ST_RUN;
                        win_d   = '0;
                    end else begin
                        win_d = win_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_RUN;
                win_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  mask_o = 1'b0;
            ST_HALT: mask_o = 1'b1;
            ST_EXIT: mask_o = 1'b1;
            default: mask_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ifc_tally.sv
module ifc_tally #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             pulse
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= count_en;
            if (clr)           count <= '0;
            else if (count_en) count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ifetch_census.sv
module ifetch_census #(
    parameter int CNT_W   = 32,
    parameter int WIN_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ifetch_req_n,
    input  logic             dbg_ack_raw,
    input  logic             dbg_restart,
    input  logic             tally_clr,
    output logic             dbg_ack_mod,
    output logic [CNT_W-1:0] fetch_tally,
    output logic             tally_pulse
);

    logic fetch_hit;
    logic count_en;

    ifc_fetch_qual u_qual (
        .ifetch_req_n (ifetch_req_n),
        .mask         (dbg_ack_mod),
        .fetch_hit    (fetch_hit),
        .count_en     (count_en)
    );

    ifc_mask_fsm #(.WIN_LEN(WIN_LEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_hit   (fetch_hit),
        .dbg_ack_raw (dbg_ack_raw),
        .dbg_restart (dbg_restart),
        .mask_o      (dbg_ack_mod)
    );

    ifc_tally #(.CNT_W(CNT_W)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .clr      (tally_clr),
        .count    (fetch_tally),
        .pulse    (tally_pulse)
    );

endmodule

// File: rtl/ifetch_census_chk.sv
module ifetch_census_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ifetch_req_n,
    input logic             dbg_ack_raw,
    input logic             tally_clr,
    input logic             dbg_ack_mod,
    input logic [CNT_W-1:0] fetch_tally,
    input logic             tally_pulse
);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!dbg_ack_mod && fetch_tally == '0 && !tally_pulse));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ifetch_req_n && !dbg_ack_mod && !tally_clr)
        |=> fetch_tally == CNT_W'($past(fetch_tally) + 1'b1));

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ifetch_req_n && !dbg_ack_mod) |=> tally_pulse);

    p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ack_mod && !tally_clr) |=> $stable(fetch_tally));

    p_masked_no_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ack_mod |=> !tally_pulse);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tally_clr |=> fetch_tally == '0);

    p_idle_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ifetch_req_n |=> !tally_pulse);

endmodule

bind ifetch_census ifetch_census_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ifetch_req_n (ifetch_req_n),
    .dbg_ack_raw  (dbg_ack_raw),
    .tally_clr    (tally_clr),
    .dbg_ack_mod  (dbg_ack_mod),
    .fetch_tally  (fetch_tally),
    .tally_pulse  (tally_pulse)
);

// File: tb/ifetch_census_bench.sv
`timescale 1ns/1ps
module ifetch_census_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_n = 1'b1;
    logic        raw = 1'b0;
    logic        rs = 1'b0;
    logic        clr = 1'b0;
    logic        mask, pulse, mask_n4, pulse_n4;
    logic [31:0] tally;
    logic [3:0]  tally_n4;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ifetch_census u_ifetch_census (
        .clk(clk), .rst_n(rst_n), .ifetch_req_n(req_n), .dbg_ack_raw(raw),
        .dbg_restart(rs), .tally_clr(clr), .dbg_ack_mod(mask),
        .fetch_tally(tally), .tally_pulse(pulse)
    );

    ifetch_census #(.CNT_W(4)) u_narrow (
        .clk(clk), .rst_n(rst_n), .ifetch_req_n(req_n), .dbg_ack_raw(raw),
        .dbg_restart(rs), .tally_clr(clr), .dbg_ack_mod(mask_n4),
        .fetch_tally(tally_n4), .tally_pulse(pulse_n4)
    );

    // {req_n, raw, restart, clr} {exp mask, exp pulse} {exp tally}
    localparam logic [13:0] VEC [28] = '{
        {4'b0000, 2'b01, 8'd1},  // R2 plain fetch
        {4'b0000, 2'b01, 8'd2},  // R2
        {4'b1100, 2'b10, 8'd2},  // R3 raw rises
        {4'b0100, 2'b10, 8'd2},  // R3 system-speed access masked
        {4'b0100, 2'b10, 8'd2},  // R3
        {4'b1000, 2'b00, 8'd2},  // R4 raw falls, no restart
        {4'b0000, 2'b01, 8'd3},  // R4 counting again
        {4'b1100, 2'b10, 8'd3},  // R3
        {4'b1110, 2'b10, 8'd3},  // R5 restart
        {4'b0100, 2'b10, 8'd3},  // R5 first window fetch
        {4'b0100, 2'b10, 8'd3},  // R5 second
        {4'b0100, 2'b00, 8'd3},  // R5 third, mask drops despite raw high
        {4'b0100, 2'b01, 8'd4},  // R6 raw high, still counted
        {4'b0000, 2'b01, 8'd5},  // R6
        {4'b1100, 2'b10, 8'd5},  // R3
        {4'b1110, 2'b10, 8'd5},  // R5 restart
        {4'b0000, 2'b10, 8'd5},  // R6 raw falls mid-window, still masked
        {4'b1100, 2'b10, 8'd5},  // R7 raw rises, window discarded
        {4'b1110, 2'b10, 8'd5},  // R7 new restart
        {4'b0100, 2'b10, 8'd5},  // R7
        {4'b0100, 2'b10, 8'd5},  // R7
        {4'b0000, 2'b00, 8'd5},  // R7 three full fetches needed
        {4'b0000, 2'b01, 8'd6},  // R2
        {4'b1010, 2'b00, 8'd6},  // R11 restart while running
        {4'b0000, 2'b01, 8'd7},  // R11
        {4'b0001, 2'b01, 8'd0},  // R8 R10 clear beats increment, pulse kept
        {4'b0000, 2'b01, 8'd1},  // R8
        {4'b1001, 2'b00, 8'd0}   // R8
    };
    localparam int VREQ [28] = '{2,2,3,3,3,4,4,3,5,5,5,5,6,6,3,5,6,7,7,7,7,7,2,11,11,8,8,8};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic a_req_n, input logic a_raw, input logic a_rs, input logic a_clr);
        @(negedge clk);
        req_n = a_req_n; raw = a_raw; rs = a_rs; clr = a_clr;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) apply(1'b1, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 mask", {31'd0, mask}, 32'd0);
        check("R1 tally", tally, 32'd0);
        check("R1 pulse", {31'd0, pulse}, 32'd0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 28; i++) begin
            string tag;
            apply(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10]);
            tag = $sformatf("R%0d step %0d", VREQ[i], i);
            check({tag, " mask"}, {31'd0, mask}, {31'd0, VEC[i][9]});
            check({tag, " pulse"}, {31'd0, pulse}, {31'd0, VEC[i][8]});
            check({tag, " tally"}, tally, {24'd0, VEC[i][7:0]});
        end

        // R1 reset in the middle of an exit window
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b1, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 1'b0);
        check("R5 mask in window", {31'd0, mask}, 32'd1);
        @(negedge clk);
        rst_n = 1'b0; raw = 1'b0; req_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-window mask", {31'd0, mask}, 32'd0);
        check("R1 mid-window tally", tally, 32'd0);
        @(negedge clk);
        rst_n = 1'b1; req_n = 1'b1;
        @(posedge clk);
        #1;

        // R9 wrap on the 4-bit instance
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 15; k++) apply(1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 narrow at max", {28'd0, tally_n4}, 32'd15);
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 narrow wrapped", {28'd0, tally_n4}, 32'd0);
        check("R9 wide no wrap", tally, 32'd16);
        check("R9 pulse on wrap", {31'd0, pulse_n4}, 32'd1);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 idle no pulse", {31'd0, pulse}, 32'd0);

        finish_run();
    end

endmodule